// File: doc/BRIEF.md
# Wake and Suspend Control Register

This block is a small host-visible control slice for the power management of a network controller. It holds five bits. A wake flag records that a wake frame arrived while wake mode was active. A flag enable routes that flag to the interrupt line. A mode bit and an enable bit together decide whether wake mode is active, and the mode bit can also be armed by an external power-good pin. A suspend bit runs a request/acknowledge handshake with the buffer manager. The block also gates a read-only ring-length value onto the read port.

The host writes the control byte with a single-cycle strobe and reads it back through a registered read port. Two reset sources, hard and soft, clear everything. The stop command drops any suspend request but leaves the wake configuration alone. The suspend bit reads back as 1 only when the request is pending and the buffer manager has acknowledged it, so software polls until it sees 1.

Top module: `pmctl_reg`

## Requirements
- R1: When `wake_active` is 1 and `wake_frame` is 1 in the same cycle, the wake flag (readback bit 4) is 1 from the next cycle on.
- R2: A control write with bit 4 set clears the wake flag, and a write with bit 4 clear leaves it unchanged. If a wake frame is set in the same cycle as the clearing write, the flag stays 1.
- R3: `irq` is registered. It is 1 in the cycle after one in which the wake flag, the flag enable (bit 3) and `gint_en` are all 1, and 0 otherwise.
- R4: `wake_active` is registered. It is 1 in the cycle after one in which the mode bit (bit 1) is 1 and either `pwr_good` or the enable bit (bit 2) is 1.
- R5: `rst` or `soft_rst` clears all five bits, `irq`, `wake_active`, `susp_req` and `rd_data` on the next edge. `stop` changes none of bits 1 to 4.
- R6: A control write with bit 0 set raises `susp_req` on the next cycle only if `stop` is 0. While `stop` is 1 the request is ignored.
- R7: A control write with bit 0 clear, or `stop`, drops `susp_req` on the next cycle. `stop` has priority over a write.
- R8: A read of the control address (0) returns, one cycle after `rd_en`, bit 0 = `susp_req` AND `susp_ack`, bits 1 to 4 as above, and upper bits 0. `rd_data` holds its value when `rd_en` is 0.
- R9: A read of the ring address (1) returns `ring_len` zero-extended while `stop` is 1 or the suspend readback bit is 1, and returns zero otherwise. Reads of other addresses return zero.
- R10: Writes to any address other than 0 change no bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Stop command level |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |
| pwr_good | input | 1 | Power-good pin that arms wake mode |
| wake_frame | input | 1 | Pulse: wake frame detected |
| gint_en | input | 1 | Global interrupt enable |
| susp_ack | input | 1 | Buffer manager reports that it is suspended |
| ring_len | input | RING_W | Ring length captured at initialization |
| irq | output | 1 | Interrupt request |
| wake_active | output | 1 | Wake mode is active |
| susp_req | output | 1 | Suspend request to the buffer manager |

## Verification
Wake-mode entry is tried with the pin alone, the enable bit alone, both, and neither. This separates an OR of the two from an AND, and shows that the mode bit gates both. The flag is driven with a clearing write alone, a write with bit 4 clear, and a clearing write that coincides with a wake frame, which checks the set-over-clear priority. Suspend is requested with stop high and with stop low, and polled with the acknowledge high and low, which tells the pending request apart from the reported status. Random cycles then mix resets, stop, writes to both addresses and reads against a per-cycle bench model.

// File: rtl/pmctl_pkg.sv
package pmctl_pkg;
  // Control byte field positions (host software decodes these)
  localparam int BIT_SUSP = 0;
  localparam int BIT_MODE = 1;
  localparam int BIT_EN   = 2;
  localparam int BIT_IE   = 3;
  localparam int BIT_FLAG = 4;

  // Register addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_RING = 1;

  typedef struct packed {
    logic flag;
    logic ie;
    logic en;
    logic mode;
  } wake_cfg_t;
endpackage

// File: rtl/pmctl_wake.sv
module pmctl_wake
  import pmctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pwr_good,
  input  logic              wake_frame,
  input  logic              gint_en,
  output wake_cfg_t         cfg,
  output logic              wake_active,
  output logic              irq
);
  logic set_flag;
  logic clr_flag;

  assign set_flag = wake_active & wake_frame;
  assign clr_flag = wr_ctrl & wr_data[BIT_FLAG];

  // Configuration bits: only resets clear them, stop does not
  always_ff @(posedge clk) begin
    if (rst_any) begin
      cfg <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.ie   <= wr_data[BIT_IE];
        cfg.en   <= wr_data[BIT_EN];
        cfg.mode <= wr_data[BIT_MODE];
      end
      if (set_flag)      cfg.flag <= 1'b1;
      else if (clr_flag) cfg.flag <= 1'b0;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst_any) begin
      wake_active <= 1'b0;
      irq         <= 1'b0;
    end else begin
      wake_active <= cfg.mode & (pwr_good | cfg.en);
      irq         <= cfg.flag & cfg.ie & gint_en;
    end
  end
endmodule

// File: rtl/pmctl_susp.sv
module pmctl_susp (
  input  logic clk,
  input  logic rst_any,
  input  logic stop,
  input  logic wr_ctrl,
  input  logic wr_bit,
  input  logic susp_ack,
  output logic susp_req,
  output logic susp_stat
);
  always_ff @(posedge clk) begin
    if (rst_any || stop) begin
      susp_req <= 1'b0;
    end else if (wr_ctrl) begin
      susp_req <= wr_bit;
    end
  end

  // Reported only once the buffer manager confirms entry
  assign susp_stat = susp_req & susp_ack;
endmodule

// File: rtl/pmctl_rdmux.sv
module pmctl_rdmux
  import pmctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int RING_W = 4
) (
  input  logic              clk,
  input  logic              rst_any,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  wake_cfg_t         cfg,
  input  logic              susp_stat,
  input  logic              stop,
  input  logic [RING_W-1:0] ring_len,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CTRL_BITS = BIT_FLAG + 1;

  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] ring_word;
  logic [DATA_W-1:0] rd_next;
  logic              ring_open;

  assign ring_open = stop | susp_stat;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_SUSP] = susp_stat;
    ctrl_word[BIT_MODE] = cfg.mode;
    ctrl_word[BIT_EN]   = cfg.en;
    ctrl_word[BIT_IE]   = cfg.ie;
    ctrl_word[BIT_FLAG] = cfg.flag;
  end

  generate
    if (RING_W >= DATA_W) begin : g_ring_trunc
      assign ring_word = ring_open ? ring_len[DATA_W-1:0] : '0;
    end else begin : g_ring_ext
      assign ring_word = ring_open ? {{(DATA_W-RING_W){1'b0}}, ring_len} : '0;
    end
    if (DATA_W < CTRL_BITS) begin : g_bad_width
      initial $error("DATA_W too small for control fields");
    end
  endgenerate

  always_comb begin
    if (rd_addr == ADDR_W'(ADDR_CTRL))      rd_next = ctrl_word;
    else if (rd_addr == ADDR_W'(ADDR_RING)) rd_next = ring_word;
    else                                    rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst_any)    rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/pmctl_reg.sv
module pmctl_reg
  import pmctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int RING_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwr_good,
  input  logic              wake_frame,
  input  logic              gint_en,
  input  logic              susp_ack,
  input  logic [RING_W-1:0] ring_len,
  output logic              irq,
  output logic              wake_active,
  output logic              susp_req
);
  logic      rst_any;
  logic      wr_ctrl;
  logic      susp_stat;
  wake_cfg_t cfg;

  assign rst_any = rst | soft_rst;
  assign wr_ctrl = wr_en & (wr_addr == ADDR_W'(ADDR_CTRL));

  pmctl_wake #(.DATA_W(DATA_W)) u_wake (
    .clk        (clk),
    .rst_any    (rst_any),
    .wr_ctrl    (wr_ctrl),
    .wr_data    (wr_data),
    .pwr_good   (pwr_good),
    .wake_frame (wake_frame),
    .gint_en    (gint_en),
    .cfg        (cfg),
    .wake_active(wake_active),
    .irq        (irq)
  );

  pmctl_susp u_susp (
    .clk      (clk),
    .rst_any  (rst_any),
    .stop     (stop),
    .wr_ctrl  (wr_ctrl),
    .wr_bit   (wr_data[BIT_SUSP]),
    .susp_ack (susp_ack),
    .susp_req (susp_req),
    .susp_stat(susp_stat)
  );

  pmctl_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RING_W(RING_W)) u_rd (
    .clk      (clk),
    .rst_any  (rst_any),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cfg      (cfg),
    .susp_stat(susp_stat),
    .stop     (stop),
    .ring_len (ring_len),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/pmctl_reg_chk.sv
module pmctl_reg_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              stop,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              wake_frame,
  input logic              gint_en,
  input logic              susp_ack,
  input logic              irq,
  input logic              wake_active,
  input logic              susp_req,
  input logic              flag,
  input logic              ie,
  input logic              en,
  input logic              mode,
  input logic              pwr_good
);
  logic wr_c;
  assign wr_c = wr_en && (wr_addr == '0);

  // R1 and R2: a wake frame during wake mode sets the flag, beating a clear
  a_r1_flag_set: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (wake_active && wake_frame) |=> flag);

  a_r2_w1c: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (wr_c && wr_data[4] && !(wake_active && wake_frame)) |=> !flag);

  a_r3_irq_on: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (flag && ie && gint_en) |=> irq);

  a_r3_irq_off: assert property (@(posedge clk) disable iff (rst || soft_rst)
    !(flag && ie && gint_en) |=> !irq);

  a_r4_active: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (mode && (pwr_good || en)) |=> wake_active);

  a_r5_stop_keeps_cfg: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (stop && !wr_c && !(wake_active && wake_frame))
      |=> ($stable(flag) && $stable(ie) && $stable(en) && $stable(mode)));

  a_r7_stop_drops_req: assert property (@(posedge clk) disable iff (rst || soft_rst)
    stop |=> !susp_req);

  a_r6_req_needs_run: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(susp_req) |-> $past(!stop && wr_c && wr_data[0]));

  a_r8_stat_needs_ack: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rd_en && rd_addr == '0 && !(susp_req && susp_ack)) |=> !rd_data[0]);

  a_r9_ring_hidden: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (rd_en && rd_addr == ADDR_W'(1) && !stop && !(susp_req && susp_ack)) |=> (rd_data == '0));
endmodule

bind pmctl_reg pmctl_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .stop       (stop),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .wake_frame (wake_frame),
  .gint_en    (gint_en),
  .susp_ack   (susp_ack),
  .irq        (irq),
  .wake_active(wake_active),
  .susp_req   (susp_req),
  .flag       (cfg.flag),
  .ie         (cfg.ie),
  .en         (cfg.en),
  .mode       (cfg.mode),
  .pwr_good   (pwr_good)
);

// File: tb/pmctl_reg_bench.sv
module pmctl_reg_bench;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int RING_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              soft_rst = 1'b0;
  logic              stop = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              pwr_good = 1'b0;
  logic              wake_frame = 1'b0;
  logic              gint_en = 1'b0;
  logic              susp_ack = 1'b0;
  logic [RING_W-1:0] ring_len = 4'hA;
  logic              irq;
  logic              wake_active;
  logic              susp_req;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R5";

  // Bench model state
  logic       m_flag, m_ie, m_en, m_mode, m_pend, m_active, m_irq;
  logic [7:0] m_rd;

  always #(CLK_P/2) clk = ~clk;

  pmctl_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RING_W(RING_W)) u_pmctl_reg (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop(stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwr_good(pwr_good), .wake_frame(wake_frame), .gint_en(gint_en),
    .susp_ack(susp_ack), .ring_len(ring_len),
    .irq(irq), .wake_active(wake_active), .susp_req(susp_req)
  );

  // R8: control byte layout
  function automatic logic [7:0] f_ctrl(input logic fl, ie, en, md, stat);
    return {3'b000, fl, ie, en, md, stat};
  endfunction

  // R9: ring value visible only under stop or reported suspend
  function automatic logic [7:0] f_ring(input logic stp, stat, input logic [3:0] rl);
    return (stp || stat) ? {4'h0, rl} : 8'h00;
  endfunction

  task automatic chk(input string what, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    logic       n_flag, n_ie, n_en, n_mode, n_pend, n_active, n_irq, stat, wr_c;
    logic [7:0] n_rd;
    stat = m_pend & susp_ack;
    wr_c = wr_en && (wr_addr == 2'd0);
    if (rst || soft_rst) begin
      {n_flag, n_ie, n_en, n_mode, n_pend, n_active, n_irq} = '0;
      n_rd = 8'h00;
    end else begin
      n_flag   = (m_active && wake_frame) ? 1'b1 : (wr_c && wr_data[4]) ? 1'b0 : m_flag;
      n_ie     = wr_c ? wr_data[3] : m_ie;
      n_en     = wr_c ? wr_data[2] : m_en;
      n_mode   = wr_c ? wr_data[1] : m_mode;
      n_pend   = stop ? 1'b0 : wr_c ? wr_data[0] : m_pend;
      n_active = m_mode & (pwr_good | m_en);
      n_irq    = m_flag & m_ie & gint_en;
      if (!rd_en)              n_rd = m_rd;
      else if (rd_addr == 2'd0) n_rd = f_ctrl(m_flag, m_ie, m_en, m_mode, stat);
      else if (rd_addr == 2'd1) n_rd = f_ring(stop, stat, ring_len);
      else                      n_rd = 8'h00;
    end
    @(posedge clk);
    #1;
    {m_flag, m_ie, m_en, m_mode, m_pend, m_active, m_irq} =
      {n_flag, n_ie, n_en, n_mode, n_pend, n_active, n_irq};
    m_rd = n_rd;
    chk("irq", "R3", {7'b0, irq}, {7'b0, m_irq});
    chk("wake_active", "R4", {7'b0, wake_active}, {7'b0, m_active});
    chk("susp_req", "R6", {7'b0, susp_req}, {7'b0, m_pend});
    chk("rd_data", "R8", rd_data, m_rd);
  endtask

  task automatic quiet();
    wr_en = 1'b0; rd_en = 1'b0; wake_frame = 1'b0; rst = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    quiet(); wr_en = 1'b1; wr_addr = a; wr_data = d; step(); quiet();
  endtask

  task automatic rd(input logic [1:0] a);
    quiet(); rd_en = 1'b1; rd_addr = a; step(); quiet();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    {m_flag, m_ie, m_en, m_mode, m_pend, m_active, m_irq} = '0;
    m_rd = 8'h00;
    // R5: reset state
    cur_tag = "R5";
    step(); step();
    chk("reset rd_data", "R5", rd_data, 8'h00);
    quiet(); step();

    // R4: pin alone, enable alone, neither, mode gating
    cur_tag = "R4";
    wr(2'd0, 8'h02); step(); step();
    chk("mode only, no pin", "R4", {7'b0, wake_active}, 8'h00);
    pwr_good = 1'b1; step(); step();
    chk("mode plus pin", "R4", {7'b0, wake_active}, 8'h01);
    pwr_good = 1'b0; wr(2'd0, 8'h06); step();
    chk("mode plus enable", "R4", {7'b0, wake_active}, 8'h01);
    wr(2'd0, 8'h04); pwr_good = 1'b1; step(); step();
    chk("enable and pin without mode", "R4", {7'b0, wake_active}, 8'h00);
    pwr_good = 1'b0;

    // R1: frame during wake mode sets the flag
    cur_tag = "R1";
    wr(2'd0, 8'h06); step();
    wake_frame = 1'b1; step(); quiet();
    rd(2'd0);
    chk("flag after frame", "R1", rd_data, 8'h16);

    // R2: write 0 keeps, simultaneous set wins, clear alone clears
    cur_tag = "R2";
    wr(2'd0, 8'h06); rd(2'd0);
    chk("write 0 keeps flag", "R2", rd_data, 8'h16);
    quiet(); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h16; wake_frame = 1'b1; step(); quiet();
    rd(2'd0);
    chk("set beats clear", "R2", rd_data, 8'h06 | 8'h10);
    wr(2'd0, 8'h16); rd(2'd0);
    chk("clear alone", "R2", rd_data, 8'h06);

    // R3: interrupt path
    cur_tag = "R3";
    wake_frame = 1'b1; step(); quiet();
    wr(2'd0, 8'h0E); gint_en = 1'b1; step(); step();
    chk("irq all enabled", "R3", {7'b0, irq}, 8'h01);
    gint_en = 1'b0; step(); step();
    chk("irq gated by global", "R3", {7'b0, irq}, 8'h00);

    // R5: stop keeps configuration, soft reset clears it
    cur_tag = "R5";
    stop = 1'b1; step(); step(); rd(2'd0);
    chk("stop keeps cfg", "R5", rd_data, 8'h1E);
    stop = 1'b0; quiet(); soft_rst = 1'b1; step(); quiet(); rd(2'd0);
    chk("soft reset clears cfg", "R5", rd_data, 8'h00);

    // R6: suspend request blocked under stop
    cur_tag = "R6";
    stop = 1'b1; wr(2'd0, 8'h01); stop = 1'b0; step();
    chk("request under stop ignored", "R6", {7'b0, susp_req}, 8'h00);
    wr(2'd0, 8'h01);
    chk("request while running", "R6", {7'b0, susp_req}, 8'h01);

    // R8: polled status needs acknowledge
    cur_tag = "R8";
    susp_ack = 1'b0; rd(2'd0);
    chk("status before ack", "R8", rd_data, 8'h00);
    // R9: ring hidden before ack, visible after
    cur_tag = "R9";
    rd(2'd1);
    chk("ring hidden", "R9", rd_data, 8'h00);
    susp_ack = 1'b1; rd(2'd0);
    chk("status after ack", "R8", rd_data, 8'h01);
    rd(2'd1);
    chk("ring while suspended", "R9", rd_data, 8'h0A);

    // R10: write to ring address changes nothing
    cur_tag = "R10";
    wr(2'd1, 8'hFF); rd(2'd0);
    chk("ring write ignored", "R10", rd_data, 8'h01);

    // R7: release by write 0, then by stop
    cur_tag = "R7";
    wr(2'd0, 8'h00);
    chk("release by write", "R7", {7'b0, susp_req}, 8'h00);
    wr(2'd0, 8'h01);
    stop = 1'b1; wr(2'd0, 8'h01);
    chk("stop beats write", "R7", {7'b0, susp_req}, 8'h00);
    rd(2'd1);
    chk("ring under stop", "R9", rd_data, 8'h0A);
    stop = 1'b0; susp_ack = 1'b0;

    // Random phase
    cur_tag = "RND";
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      rst        = ($urandom % 80) == 0;
      soft_rst   = ($urandom % 80) == 0;
      stop       = ($urandom % 8) == 0;
      wr_en      = ($urandom % 3) == 0;
      wr_addr    = 2'($urandom % 4);
      wr_data    = 8'($urandom);
      rd_en      = ($urandom % 2) == 0;
      rd_addr    = 2'($urandom % 4);
      pwr_good   = ($urandom % 2) == 0;
      wake_frame = ($urandom % 4) == 0;
      gint_en    = ($urandom % 4) != 0;
      susp_ack   = ($urandom % 2) == 0;
      ring_len   = 4'($urandom);
      step();
    end
    quiet(); step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule